// File: doc/BRIEF.md
# Cascaded Unequal Moving-Average Bitstream Filter

This block turns a 1-bit sigma-delta modulator output into a multi-bit sample. It does this by running the bit through three moving averages, one after another. Their window lengths are 31, 11 and 3 samples. Because the three lengths differ, the combined impulse response is a smooth trapezoid. It has 43 taps and its weights sum to 31·11·3 = 1023, so a steady all-ones input produces the full-scale value 1023.

No stage stores a full running sum. Each stage keeps a short window of small difference values and passes on only a difference:

- The first stage holds the last 31 input bits.
- The second stage holds 11 two-bit differences.
- The third stage holds 3 three-bit differences.

A chain of three accumulators at the end integrates the final four-bit difference three times. This rebuilds the exact filtered value every clock. A new sample is produced on every clock, and a flag reports when the full 43-bit window holds post-reset data.

Top module: `cma_filter`

## Requirements
- R1: While `rst_n` is low, `bit_i` is ignored. At the first clock edge after reset is asserted, `sum_o` is 0 and `valid_o` is 0. After reset is released, the output depends only on bits that entered after release, as if every earlier bit were 0.
- R2: The bit sampled at post-reset edge t (edges numbered from 0) affects `sum_o` from edge t+3 onward. After edge e, `sum_o` equals Σ h[j]·x[e−3−j] for j = 0..42. Bits before edge 0 count as 0, and the result is 0 when e < 3.
- R3: The kernel h is the convolution of boxes of length 31, 11 and 3:
  - it rises 1, 3, 6, 9, … 30, 32;
  - it holds 33 for 19 taps;
  - it falls symmetrically.
  A single 1 followed by zeros reproduces h on `sum_o`.
- R4: `sum_o` is an unsigned 10-bit value. An input held at 1 for 43 or more bits gives exactly 1023, with no wrap.
- R5: Between consecutive clocks outside reset, `sum_o` changes by at most 33, the peak kernel weight.
- R6: `valid_o` is 0 up to and including post-reset edge 44. It is 1 from edge 45 onward (the 46th edge after release) and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bitstream sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_i | input | 1 | Modulator bitstream sample |
| sum_o | output | 10 | Filtered value, 0..1023 |
| valid_o | output | 1 | High once a full window of post-reset bits is reflected in `sum_o` |

## Verification
A bit driven before edge t first appears in `sum_o` after edge t+3, and `valid_o` rises after edge 45 counted from reset release. The bench drives each bit half a period before the capturing edge. It samples both outputs at the following falling edge. It then compares them with a behavioural convolution that looks back exactly three captured bits, so every comparison lands in the cycle the output is due. Impulse, constant-ones, pseudo-random and alternating patterns are run in turn. Resets are applied with non-zero history in the window, to show that nothing from before the reset leaks into the result.

// File: rtl/cma_pkg.sv
// Package: shared defaults and derived sizes for the cascaded moving-average
// filter. Assumes the three window lengths are positive.
package cma_pkg;
    parameter int DEF_LEN_A = 31;
    parameter int DEF_LEN_B = 11;
    parameter int DEF_LEN_C = 3;
    // Register stages between bit capture and the accumulated output.
    parameter int PIPE_STAGES = 3;

    // Peak kernel weight: product of the lengths with the largest left out.
    function automatic int peak_weight(input int a, input int b, input int c);
        int big;
        big = (a >= b && a >= c) ? a : ((b >= c) ? b : c);
        return (a * b * c) / big;
    endfunction

    // Number of taps in the combined kernel.
    function automatic int kernel_taps(input int a, input int b, input int c);
        return a + b + c - 2;
    endfunction
endpackage

// File: rtl/cma_diff_stage.sv
// Module: one moving-average stage that works on differences. It keeps the
// last DEPTH input values and registers (newest - value leaving the window),
// which is the first difference of the stage's moving sum.
// Assumes: the input is either an unsigned bit (IN_SIGNED=0) or a signed
// difference from an earlier stage, and that |output| never exceeds MAX_MAG.
module cma_diff_stage #(
    parameter int DEPTH     = 31,
    parameter int IN_W      = 1,
    parameter bit IN_SIGNED = 1'b0,
    parameter int MAX_MAG   = 1,
    localparam int OUT_W    = IN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    logic [IN_W-1:0]         hist_q [DEPTH];
    logic signed [OUT_W-1:0] new_ext;
    logic signed [OUT_W-1:0] old_ext;
    logic [OUT_W-1:0]        dout_q;

    // Widen the newest and the oldest entries; the generate picks the extension kind.
    generate
        if (IN_SIGNED) begin : g_sext
            assign new_ext = {din[IN_W-1], din};
            assign old_ext = {hist_q[DEPTH-1][IN_W-1], hist_q[DEPTH-1]};
        end else begin : g_zext
            assign new_ext = {1'b0, din};
            assign old_ext = {1'b0, hist_q[DEPTH-1]};
        end
    endgenerate

    // Shift the window and register the difference entering minus leaving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
            dout_q <= '0;
        end else begin
            hist_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
            dout_q <= new_ext - old_ext;
        end
    end

    assign dout = dout_q;

    // R2: a stage difference stays inside the range the next stage is sized for
    delta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(dout_q) <= MAX_MAG) && ($signed(dout_q) >= -MAX_MAG));
endmodule

// File: rtl/cma_accum_chain.sv
// Module: NUM accumulators in series. Each clock the first adds the
// sign-extended input difference, and every later one adds the freshly updated
// value of the one before. This undoes NUM levels of differencing.
// Assumes: the true result fits in OUT_W unsigned bits, so modular wrap in the
// intermediate accumulators cancels out.
module cma_accum_chain #(
    parameter int NUM   = 3,
    parameter int IN_W  = 4,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  delta,
    output logic [OUT_W-1:0] total
);
    logic [OUT_W-1:0] acc_q   [NUM];
    logic [OUT_W-1:0] acc_nxt [NUM];
    logic [OUT_W-1:0] delta_ext;

    // Sign-extend the incoming difference to accumulator width.
    assign delta_ext = {{(OUT_W-IN_W){delta[IN_W-1]}}, delta};

    // Build the chained next values, one adder per accumulator.
    generate
        for (genvar k = 0; k < NUM; k++) begin : g_acc
            if (k == 0) begin : g_head
                assign acc_nxt[k] = acc_q[k] + delta_ext;
            end else begin : g_tail
                assign acc_nxt[k] = acc_q[k] + acc_nxt[k-1];
            end
        end
    endgenerate

    // Register every accumulator at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) acc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) acc_q[i] <= acc_nxt[i];
        end
    end

    assign total = acc_q[NUM-1];
endmodule

// File: rtl/cma_fill_track.sv
// Module: counts clocks since reset release, stops at FILL, and flags when
// the count is reached.
// Assumes: one sample enters per clock, so clocks equal samples.
module cma_fill_track #(
    parameter int FILL  = 46,
    localparam int CNT_W = $clog2(FILL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic full
);
    logic [CNT_W-1:0] cnt_q;

    // Count up after reset, holding at FILL.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (cnt_q != CNT_W'(FILL))  cnt_q <= cnt_q + 1'b1;
    end

    assign full = (cnt_q == CNT_W'(FILL));

    // R6: once raised, the flag stays high until reset
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);
endmodule

// File: rtl/cma_filter.sv
// Module: top of the cascaded unequal moving-average bitstream filter.
// The chain is three difference stages of lengths LEN_A, LEN_B and LEN_C,
// followed by three accumulators. The output is the exact 43-tap trapezoid
// convolution, three clocks after a bit is captured.
// Assumes: a new bit on every clock and a synchronous active-low reset.
module cma_filter #(
    parameter int LEN_A  = cma_pkg::DEF_LEN_A,
    parameter int LEN_B  = cma_pkg::DEF_LEN_B,
    parameter int LEN_C  = cma_pkg::DEF_LEN_C,
    localparam int SUM_W = $clog2(LEN_A * LEN_B * LEN_C + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [SUM_W-1:0] sum_o,
    output logic             valid_o
);
    localparam int TAPS  = cma_pkg::kernel_taps(LEN_A, LEN_B, LEN_C);
    localparam int FILL  = TAPS + cma_pkg::PIPE_STAGES;
    localparam int PEAK  = cma_pkg::peak_weight(LEN_A, LEN_B, LEN_C);
    localparam int D1_W  = 2;
    localparam int D2_W  = 3;
    localparam int D3_W  = 4;

    logic [D1_W-1:0] d1;
    logic [D2_W-1:0] d2;
    logic [D3_W-1:0] d3;

    // Stage A: window of raw bits, difference in {-1,0,1}.
    cma_diff_stage #(.DEPTH(LEN_A), .IN_W(1), .IN_SIGNED(1'b0), .MAX_MAG(1)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .din(bit_i), .dout(d1));

    // Stage B: window of stage-A differences, difference in [-2,2].
    cma_diff_stage #(.DEPTH(LEN_B), .IN_W(D1_W), .IN_SIGNED(1'b1), .MAX_MAG(2)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .din(d1), .dout(d2));

    // Stage C: window of stage-B differences, difference in [-4,4].
    cma_diff_stage #(.DEPTH(LEN_C), .IN_W(D2_W), .IN_SIGNED(1'b1), .MAX_MAG(4)) u_stage_c (
        .clk(clk), .rst_n(rst_n), .din(d2), .dout(d3));

    // Three accumulators rebuild the full filtered value.
    cma_accum_chain #(.NUM(3), .IN_W(D3_W), .OUT_W(SUM_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .delta(d3), .total(sum_o));

    // Window-filled flag.
    cma_fill_track #(.FILL(FILL)) u_fill (
        .clk(clk), .rst_n(rst_n), .full(valid_o));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0) && !valid_o);

    // R5
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_o >= $past(sum_o)) ? (sum_o - $past(sum_o)) : ($past(sum_o) - sum_o))
            <= SUM_W'(PEAK));
endmodule

// File: tb/cma_filter_tb.sv
module cma_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTAPS = 43;
    localparam int LAT = 3;
    localparam int VALID_EDGE = 45;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_i = 1'b0;
    logic [9:0] sum_o;
    logic       valid_o;

    int checks = 0;
    int failures = 0;
    int h [NTAPS];
    int xs [4096];
    int n = 0;
    int prev_sum = 0;
    bit done = 1'b0;

    cma_filter u_dut (.clk(clk), .rst_n(rst_n), .bit_i(bit_i), .sum_o(sum_o), .valid_o(valid_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s edge=%0d actual=%0d expected=%0d", req, n, act, exp);
        end
    endtask

    function automatic int expect_sum(input int e);
        int acc = 0;
        int t = e - LAT;
        for (int j = 0; j < NTAPS; j++)
            if (t - j >= 0) acc += h[j] * xs[t-j];
        return acc;
    endfunction

    // R1: reset with input driven high, outputs must clear
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 sum in reset", int'(sum_o), 0);
        check("R1 valid in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        bit_i = 1'b0;
        n = 0;
        prev_sum = 0;
    endtask

    // Drive one bit, then compare at the next falling edge (R2 R5 R6 plus tag)
    task automatic step(input bit b, input string tag);
        int diff;
        bit_i = b;
        xs[n] = int'(b);
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(sum_o), expect_sum(n));
        check("R6 valid", int'(valid_o), (n >= VALID_EDGE) ? 1 : 0);
        diff = int'(sum_o) - prev_sum;
        if (diff < 0) diff = -diff;
        check("R5 step within 33", (diff <= 33) ? 1 : 0, 1);
        prev_sum = int'(sum_o);
        n++;
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int j = 0; j < NTAPS; j++) h[j] = 0;
        for (int a = 0; a < 31; a++)
            for (int b = 0; b < 11; b++)
                for (int c = 0; c < 3; c++)
                    h[a+b+c]++;

        do_reset();
        // R3: impulse reproduces the kernel
        step(1'b1, "R3 impulse");
        for (int i = 0; i < 60; i++) step(1'b0, "R3 impulse");

        // R4: constant ones reach full scale
        do_reset();
        for (int i = 0; i < 100; i++) step(1'b1, "R4 ones");
        check("R4 full scale", int'(sum_o), 1023);

        // R1: history of ones must not survive reset; R2 random stream
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            step(lfsr[0], "R2 random");
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        for (int i = 0; i < 100; i++) step(i[0], "R2 alternating");

        // R1: reset with busy history, then zeros must give zero
        do_reset();
        for (int i = 0; i < 50; i++) step(1'b0, "R1 cleared history");
        for (int i = 0; i < 20; i++) step(1'b1, "R2 step up");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule